// File: doc/BRIEF.md
# Bus Transaction Watchdog and Elapsed-Time Monitor

This block times transactions on an auxiliary bus. A one-cycle start strobe opens a measurement and a one-cycle end strobe closes it. In between, a counter advances once per scaled tick. The scaled tick is a 100 ns base tick, taken from the system clock by a parameterised divider, and then divided by 2 to the power of a 2-bit scale exponent. When the count goes past a programmed 8-bit limit, the block raises HALT and a sticky timeout flag. A limit of zero turns the watchdog off.

When a transaction closes, the block copies the running count into a read-only elapsed register and sets an elapsed flag. This lets software measure bus occupancy without any overhead. The same exponent sets the time unit for both the limit and the captured duration, so one unit equals 100 ns times 2^scale. The counter stops at 0xFF and does not wrap.

Software uses a byte-wide register port with combinational read data.

Top module: `bus_watchdog_timer`

## Requirements
- R1: After reset, halt is 0. The limit (address 0), status (address 1) and elapsed (address 2) registers all read 0x00.
- R2: One count unit lasts CLK_PER_BASE*2^scale clock cycles, with the tick phase restarted at each start strobe. An end strobe sampled W+1 clock edges after the start strobe captures min(floor(W/(CLK_PER_BASE*2^scale)),255).
- R3: With a nonzero limit, halt and the timeout flag set on the tick at which the count becomes limit+1, provided the transaction is still open. Halt is therefore set exactly when the captured duration exceeds the limit.
- R4: A limit of 0x00 disables the watchdog. No transaction, however long, sets halt or the timeout flag.
- R5: An end strobe during an open transaction latches the count into the elapsed register and sets the elapsed flag (status bit 2). The elapsed register changes at no other time.
- R6: The count saturates at 0xFF. A transaction longer than 255 units reports 0xFF, and a limit of 0xFF never times out.
- R7: Halt and the timeout flag (status bit 3) stay set across further transactions until reset, or until a status write with bit 3 set, which clears both. Writing bit 2 set clears the elapsed flag.
- R8: The status register reads {4'b0, timeout, elapsed flag, scale[1:0]}. A status write loads scale from bits 1:0. Writes to address 2 are ignored, and address 3 reads 0x00.
- R9: A start strobe during an open transaction restarts the measurement from a count of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| xact_start | input | 1 | One-cycle transaction start strobe |
| xact_end | input | 1 | One-cycle transaction end strobe |
| halt | output | 1 | Sticky watchdog halt |

## Verification
The assertions assume the following about the inputs:
- start and end strobes never share a cycle;
- the limit register is not rewritten on the same edge that a tick lands;
- status clears arrive only through bit 3 of a status write.

The stimulus keeps within these limits. It drives each strobe for exactly one cycle at the falling edge. It writes the limit and scale only while no transaction is open. Each transaction length is chosen so that the expected capture and halt follow from the floor formula in R2.

// File: rtl/bus_watchdog_timer.sv
module bus_watchdog_timer #(
  parameter int CLK_PER_BASE = 20,
  parameter int CNT_W        = 8,
  parameter int SCALE_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             xact_start,
  input  logic             xact_end,
  output logic             halt
);

  localparam int DIV_W = (CLK_PER_BASE > 1) ? $clog2(CLK_PER_BASE) : 1;
  localparam int PRE_W = (2 ** SCALE_W) - 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_BASE - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [DIV_W-1:0]   div_q;
  logic [PRE_W-1:0]   pre_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   limit_q;
  logic [CNT_W-1:0]   elapsed_q;
  logic [SCALE_W-1:0] scale_q;
  logic               busy_q;
  logic               tmo_q;
  logic               elf_q;

  logic               base_tick;
  logic               unit_tick;
  logic [PRE_W-1:0]   pre_mask;
  logic               closing;
  logic               trip;
  logic               wr_limit;
  logic               wr_stat;

  assign pre_mask  = PRE_W'((1 << scale_q) - 1);
  assign base_tick = busy_q && (div_q == DIV_LAST);
  assign unit_tick = base_tick && ((pre_q & pre_mask) == pre_mask);
  assign closing   = busy_q && xact_end && !xact_start;
  assign trip      = busy_q && !xact_start && !xact_end && unit_tick &&
                     (limit_q != '0) && (cnt_q == limit_q) && (cnt_q != CNT_MAX);
  assign wr_limit  = reg_wr && (reg_addr == 2'd0);
  assign wr_stat   = reg_wr && (reg_addr == 2'd1);
  assign halt      = tmo_q;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = 8'(limit_q);
      2'd1:    reg_rdata = {4'b0, tmo_q, elf_q, 2'(scale_q)};
      2'd2:    reg_rdata = 8'(elapsed_q);
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      pre_q <= '0;
      cnt_q <= '0;
      busy_q <= 1'b0;
    end else if (xact_start) begin
      div_q <= '0;
      pre_q <= '0;
      cnt_q <= '0;
      busy_q <= 1'b1;
    end else begin
      if (busy_q) div_q <= base_tick ? '0 : div_q + 1'b1;
      if (base_tick) pre_q <= pre_q + 1'b1;
      if (unit_tick && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (xact_end) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limit_q   <= '0;
      scale_q   <= '0;
      elapsed_q <= '0;
      elf_q     <= 1'b0;
      tmo_q     <= 1'b0;
    end else begin
      if (wr_limit) limit_q <= reg_wdata[CNT_W-1:0];
      if (wr_stat)  scale_q <= reg_wdata[SCALE_W-1:0];
      if (closing) begin
        elapsed_q <= cnt_q;
        elf_q     <= 1'b1;
      end else if (wr_stat && reg_wdata[2]) begin
        elf_q     <= 1'b0;
      end
      if (trip)                          tmo_q <= 1'b1;
      else if (wr_stat && reg_wdata[3])  tmo_q <= 1'b0;
    end
  end

  assert_halt_over_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt) |-> (cnt_q > limit_q));

  assert_zero_limit_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_q == '0) |=> !$rose(halt));

  assert_elapsed_only_on_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && xact_end) |=> $stable(elapsed_q));

  assert_count_saturates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !xact_start && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !(reg_wr && reg_addr == 2'd1 && reg_wdata[3])) |=> halt);

  assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xact_start |=> (cnt_q == '0 && busy_q));

endmodule

// File: tb/bus_watchdog_timer_tb_top.sv
module bus_watchdog_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       xact_start = 1'b0;
  logic       xact_end = 1'b0;
  logic       halt;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  bus_watchdog_timer #(.CLK_PER_BASE(20), .CNT_W(8), .SCALE_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xact_start(xact_start),
    .xact_end(xact_end), .halt(halt));

  // limit, scale, wait W, expected elapsed, expected halt
  localparam int NV = 11;
  localparam int VEC [NV][5] = '{
    '{10, 0,  100,   5, 0},
    '{ 3, 0,   95,   4, 1},
    '{ 3, 0,   79,   3, 0},
    '{ 3, 0,   80,   4, 1},
    '{ 2, 1,  130,   3, 1},
    '{ 2, 1,  119,   2, 0},
    '{ 0, 0,  300,  15, 0},
    '{ 5, 2,  500,   6, 1},
    '{ 1, 3,  170,   1, 0},
    '{255,0, 6000, 255, 0},
    '{100,0, 6000, 255, 1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    #1 v = int'(reg_rdata);
  endtask

  task automatic xact(input int w);
    @(negedge clk); xact_start = 1'b1;
    @(negedge clk); xact_start = 1'b0;
    repeat (w) @(negedge clk);
    xact_end = 1'b1;
    @(negedge clk); xact_end = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 halt", int'(halt), 0);
    rd(2'd0, v); chk("R1 limit", v, 0);
    rd(2'd1, v); chk("R1 status", v, 0);
    rd(2'd2, v); chk("R1 elapsed", v, 0);

    for (int i = 0; i < NV; i++) begin
      wr(2'd0, 8'(VEC[i][0]));
      wr(2'd1, 8'(VEC[i][1]) | 8'h0C);
      xact(VEC[i][2]);
      rd(2'd2, v); chk($sformatf("R2/R5/R6 vec%0d elapsed", i), v, VEC[i][3]);
      #1 chk($sformatf("R3/R4 vec%0d halt", i), int'(halt), VEC[i][4]);
      rd(2'd1, v);
      chk($sformatf("R8 vec%0d status", i), v, (VEC[i][4] << 3) | 4 | VEC[i][1]);
    end

    // R7: halt survives a later short transaction, then W1C clears
    wr(2'd0, 8'd2);
    wr(2'd1, 8'h0C);
    xact(100);
    #1 chk("R7 set", int'(halt), 1);
    xact(10);
    #1 chk("R7 sticky", int'(halt), 1);
    rd(2'd2, v); chk("R5 short capture", v, 0);
    wr(2'd1, 8'h08);
    #1 chk("R7 clear halt", int'(halt), 0);
    rd(2'd1, v); chk("R7 elapsed flag kept", v, 8'h04);
    wr(2'd1, 8'h05);
    rd(2'd1, v); chk("R7 clear elapsed flag, R8 scale", v, 8'h01);

    // R8: elapsed not writable, address 3 reads zero
    wr(2'd2, 8'hA5);
    rd(2'd2, v); chk("R8 elapsed write ignored", v, 0);
    rd(2'd3, v); chk("R8 addr3", v, 0);

    // R9: restart mid-transaction
    wr(2'd1, 8'h00);
    wr(2'd0, 8'd0);
    @(negedge clk); xact_start = 1'b1;
    @(negedge clk); xact_start = 1'b0;
    repeat (150) @(negedge clk);
    xact(50);
    rd(2'd2, v); chk("R9 restart", v, 2);

    // R5: end with no open transaction leaves elapsed alone
    @(negedge clk); xact_end = 1'b1;
    @(negedge clk); xact_end = 1'b0;
    rd(2'd2, v); chk("R5 stray end", v, 2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule